// File: doc/BRIEF.md
# Periodic Peripheral Poll Scheduler

The scheduler sits between a host transfer engine and a slow serial peripheral bus. When it is enabled it counts milliseconds and, each time the programmed poll period runs out, raises a one-cycle poll strobe. The strobe carries the current 16-bit selection of peripheral addresses. A responder answers each poll with up to eight data bytes. A non-empty answer is written, one byte per cycle, into the inbound response buffer as an unsolicited packet. That packet starts with a bus-type byte and a polled-data marker byte, and the data bytes follow.

Software programs three things: the period in milliseconds, the selection mask as a short byte sequence, and an enable level. The host transfer engine sends a block pulse when a host-to-device packet begins and an unblock pulse after the last byte of the device-to-host reply has left. No poll goes out while the block is in force. A period expiry that falls inside the block is remembered as a single pending poll, which is issued as soon as the block lifts.

Top module: `autopoll_sched`

## Requirements
- R1: After reset `poll_req` and `pkt_wr_en` are 0 and `poll_mask` is 0x0000. Polling stays off until `en` is 1, and no poll strobe appears while `en` is 0.
- R2: With `en` high, the first poll strobe appears P*CYC_PER_MS cycles after `en` rises or after an accepted period write. P is the period in ms. Later strobes follow at that same interval while polling is neither blocked nor busy.
- R3: A period write with the value 0 is ignored. The previous period stays in force.
- R4: The mask is loaded from two `mask_we` byte writes, high byte first. `poll_mask` shows the new 16-bit value from the cycle after the second write.
- R5: `poll_req` is high for exactly one cycle and carries `poll_mask`. No new poll is issued until the responder has answered and any resulting packet has been written out.
- R6: An answer with length L>0 (`rsp_valid` high while a poll is outstanding) produces L+2 buffer writes on consecutive cycles, starting the cycle after the answer. The bytes are 0x00, then 0x40, then data byte 0 (`rsp_data[7:0]`) upward. `pkt_wr_last` is set on the final byte only.
- R7: An answer with length 0 produces no buffer write.
- R8: No poll is issued while blocked. Any number of period expiries during the block collapse into one pending poll. That poll is issued on the second clock edge after the unblock pulse is applied, and the period grid is not shifted.
- R9: At most 8 data bytes are forwarded. A reported length above 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Polling enable level |
| period_we | input | 1 | Period write strobe |
| period_ms | input | PER_W | Poll period in milliseconds (0 rejected) |
| mask_we | input | 1 | Mask byte write strobe |
| mask_byte | input | 8 | Mask byte, high byte first |
| host_block | input | 1 | Pulse: host transaction started (wins over unblock) |
| host_unblock | input | 1 | Pulse: host transaction finished |
| poll_req | output | 1 | One-cycle poll strobe |
| poll_mask | output | MASK_W | Current peripheral selection mask |
| rsp_valid | input | 1 | Responder answer valid |
| rsp_len | input | $clog2(MAX_BYTES+1) | Number of returned bytes |
| rsp_data | input | 8*MAX_BYTES | Returned bytes, byte 0 in the low octet |
| pkt_wr_en | output | 1 | Buffer write enable |
| pkt_wr_data | output | 8 | Buffer write byte |
| pkt_wr_last | output | 1 | Final byte of the packet |

## Verification
The collision of interest comes when the period counter expires in the same cycle that a pending poll from a blocked interval is released. Issuing the held poll and noting the fresh expiry then happen on one edge, and a faulty merge would leave a second poll pending. The bench provokes this by blocking across one expiry and lifting the block so that the release lands exactly on the next expiry. It then requires exactly one strobe there, silence for the following nine cycles and the next strobe one full period later. It also blocks across three expiries to confirm they yield only a single poll.

// File: rtl/ap_pkg.sv
// Shared constants and types for the poll scheduler.
// Assumes byte-wide packet buffer writes.
package ap_pkg;
    localparam logic [7:0] AP_TYPE_BUS  = 8'h00;   // packet type byte
    localparam logic [7:0] AP_MARK_POLL = 8'h40;   // unsolicited marker byte
    localparam int         AP_HDR_BYTES = 2;

    typedef enum logic [0:0] {
        SCH_IDLE = 1'b0,
        SCH_WAIT = 1'b1
    } sch_state_t;
endpackage

// File: rtl/ap_cfg.sv
// Configuration registers: poll period with zero rejection, and a
// selection mask assembled from byte writes, most significant first.
// Assumes MASK_W is a multiple of 8 and at least 16.
module ap_cfg #(
    parameter int PER_W   = 8,
    parameter int MASK_W  = 16,
    parameter int DEF_PER = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_we,
    input  logic [PER_W-1:0]  period_ms,
    input  logic              mask_we,
    input  logic [7:0]        mask_byte,
    output logic [PER_W-1:0]  period_q,
    output logic              period_load,
    output logic [MASK_W-1:0] mask_q
);
    localparam int MB = MASK_W / 8;
    localparam int CW = (MB > 1) ? $clog2(MB) : 1;

    logic [MASK_W-9:0] acc_q;
    logic [CW-1:0]     cnt_q;

    assign period_load = period_we && (period_ms != '0);

    // Hold the period; a zero write is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            period_q <= PER_W'(DEF_PER);
        else if (period_load)
            period_q <= period_ms;
    end

    // Shift in mask bytes and commit the full word on the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            cnt_q  <= '0;
            mask_q <= '0;
        end else if (mask_we) begin
            if (cnt_q == CW'(MB - 1)) begin
                mask_q <= {acc_q, mask_byte};
                cnt_q  <= '0;
            end else begin
                acc_q  <= (MASK_W-8)'({acc_q, mask_byte});
                cnt_q  <= cnt_q + CW'(1);
            end
        end
    end
endmodule

// File: rtl/ap_ms_tick.sv
// Millisecond prescaler: pulses once every CYC_PER_MS cycles while run
// is high. Restart or a low run level clears the phase.
module ap_ms_tick #(
    parameter int CYC_PER_MS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;

    logic [W-1:0] cnt_q;

    assign tick = run && (cnt_q == W'(CYC_PER_MS - 1));

    // Count cycles within the current millisecond.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/ap_period_ctr.sv
// Period counter in milliseconds: flags due on the tick that ends a
// period and reloads. Assumes the period value is never zero.
module ap_period_ctr #(
    parameter int PER_W   = 8,
    parameter int DEF_PER = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [PER_W-1:0] reload_val,
    input  logic [PER_W-1:0] period_q,
    output logic             due
);
    logic [PER_W-1:0] rem_q;

    assign due = tick && (rem_q == PER_W'(1));

    // Track milliseconds left in the running period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rem_q <= PER_W'(DEF_PER);
        else if (restart)
            rem_q <= reload_val;
        else if (tick)
            rem_q <= (rem_q == PER_W'(1)) ? period_q : rem_q - PER_W'(1);
    end
endmodule

// File: rtl/ap_emit.sv
// Packet emitter: writes the two header bytes and then the captured
// data bytes, one per cycle. Lengths above MAX_BYTES are clamped.
// Assumes load is only raised with a non-zero length while idle.
module ap_emit
    import ap_pkg::*;
#(
    parameter int MAX_BYTES = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [$clog2(MAX_BYTES+1)-1:0] len,
    input  logic [8*MAX_BYTES-1:0]      data,
    output logic                        busy,
    output logic [7:0]                  wr_data,
    output logic                        wr_last
);
    localparam int LW = $clog2(MAX_BYTES + 1);
    localparam int IW = $clog2(MAX_BYTES + AP_HDR_BYTES);

    logic [IW-1:0]          idx_q;
    logic [LW-1:0]          len_q;
    logic [8*MAX_BYTES-1:0] data_q;
    logic [7:0]             bytes [MAX_BYTES];
    logic [LW-1:0]          len_c;

    genvar g;
    generate
        for (g = 0; g < MAX_BYTES; g++) begin : g_byte
            assign bytes[g] = data_q[8*g +: 8];
        end
    endgenerate

    assign len_c   = (len > LW'(MAX_BYTES)) ? LW'(MAX_BYTES) : len;
    assign wr_last = busy && (idx_q == IW'(len_q) + IW'(1));

    // Pick the byte for the current write slot.
    always_comb begin
        wr_data = AP_TYPE_BUS;
        if (idx_q == IW'(1))
            wr_data = AP_MARK_POLL;
        for (int i = 0; i < MAX_BYTES; i++) begin
            if (idx_q == IW'(i + AP_HDR_BYTES))
                wr_data = bytes[i];
        end
    end

    // Capture the answer and step through the packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            idx_q  <= '0;
            len_q  <= '0;
            data_q <= '0;
        end else if (load) begin
            busy   <= 1'b1;
            idx_q  <= '0;
            len_q  <= len_c;
            data_q <= data;
        end else if (busy) begin
            if (wr_last)
                busy <= 1'b0;
            else
                idx_q <= idx_q + IW'(1);
        end
    end
endmodule

// File: rtl/autopoll_sched.sv
// Poll scheduler top: issues a poll strobe on each period expiry while
// enabled and not blocked, holds one pending poll across a block, and
// forwards non-empty answers as unsolicited packets.
// Assumes the responder answers each poll exactly once.
module autopoll_sched
    import ap_pkg::*;
#(
    parameter int CYC_PER_MS = 100000,
    parameter int PER_W      = 8,
    parameter int DEF_PER    = 11,
    parameter int MASK_W     = 16,
    parameter int MAX_BYTES  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           en,
    input  logic                           period_we,
    input  logic [PER_W-1:0]               period_ms,
    input  logic                           mask_we,
    input  logic [7:0]                     mask_byte,
    input  logic                           host_block,
    input  logic                           host_unblock,
    output logic                           poll_req,
    output logic [MASK_W-1:0]              poll_mask,
    input  logic                           rsp_valid,
    input  logic [$clog2(MAX_BYTES+1)-1:0] rsp_len,
    input  logic [8*MAX_BYTES-1:0]         rsp_data,
    output logic                           pkt_wr_en,
    output logic [7:0]                     pkt_wr_data,
    output logic                           pkt_wr_last
);
    sch_state_t       st_q;
    logic             blk_q, pend_q, poll_q;
    logic [PER_W-1:0] period_q, reload_val;
    logic             period_load, restart, tick, due;
    logic             emit_busy, emit_load, waiting_rsp, idle, go;

    ap_cfg #(.PER_W(PER_W), .MASK_W(MASK_W), .DEF_PER(DEF_PER)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .period_we(period_we), .period_ms(period_ms),
        .mask_we(mask_we), .mask_byte(mask_byte),
        .period_q(period_q), .period_load(period_load), .mask_q(poll_mask)
    );

    assign restart    = period_load || !en;
    assign reload_val = period_load ? period_ms : period_q;

    ap_ms_tick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(en), .restart(restart), .tick(tick)
    );

    ap_period_ctr #(.PER_W(PER_W), .DEF_PER(DEF_PER)) u_per (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
        .reload_val(reload_val), .period_q(period_q), .due(due)
    );

    assign waiting_rsp = (st_q == SCH_WAIT);
    assign idle        = (st_q == SCH_IDLE) && !emit_busy;
    assign go          = en && !blk_q && idle && (pend_q || due);
    assign emit_load   = waiting_rsp && rsp_valid && (rsp_len != '0);

    ap_emit #(.MAX_BYTES(MAX_BYTES)) u_emit (
        .clk(clk), .rst_n(rst_n), .load(emit_load), .len(rsp_len),
        .data(rsp_data), .busy(emit_busy), .wr_data(pkt_wr_data),
        .wr_last(pkt_wr_last)
    );

    assign pkt_wr_en = emit_busy;
    assign poll_req  = poll_q;

    // Block flag; a block pulse wins over a simultaneous unblock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            blk_q <= 1'b0;
        else if (host_block)
            blk_q <= 1'b1;
        else if (host_unblock)
            blk_q <= 1'b0;
    end

    // Single pending poll: set by an expiry, cleared when a poll issues.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            pend_q <= 1'b0;
        else
            pend_q <= (pend_q || due) && !go;
    end

    // Poll sequencing and the one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SCH_IDLE;
            poll_q <= 1'b0;
        end else begin
            poll_q <= go;
            if (go)
                st_q <= SCH_WAIT;
            else if (waiting_rsp && rsp_valid)
                st_q <= SCH_IDLE;
        end
    end
endmodule

// File: rtl/ap_sched_checker.sv
// Protocol checker for the poll scheduler, attached by bind.
module ap_sched_checker #(
    parameter int PER_W     = 8,
    parameter int MAX_BYTES = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           en,
    input logic                           poll_req,
    input logic                           blocked,
    input logic                           waiting,
    input logic                           rsp_valid,
    input logic [$clog2(MAX_BYTES+1)-1:0] rsp_len,
    input logic                           pkt_wr_en,
    input logic [7:0]                     pkt_wr_data,
    input logic                           pkt_wr_last,
    input logic [PER_W-1:0]               period_q
);
    logic [7:0] wr_cnt_q;

    // Count bytes already written in the current packet.
    always_ff @(posedge clk) begin
        if (!rst_n || !pkt_wr_en || pkt_wr_last)
            wr_cnt_q <= '0;
        else
            wr_cnt_q <= wr_cnt_q + 8'd1;
    end

    p_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |-> $past(en));

    p_period_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        period_q != '0);

    p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |=> !poll_req);

    p_type_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_wr_en) |-> pkt_wr_data == 8'h00);

    p_marker_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_wr_en) |=> pkt_wr_en && pkt_wr_data == 8'h40);

    p_empty_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && rsp_valid && rsp_len == '0) |=> !pkt_wr_en);

    p_no_poll_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |-> !$past(blocked));

    p_len_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_wr_en |-> wr_cnt_q <= 8'(MAX_BYTES + 1));
endmodule

bind autopoll_sched ap_sched_checker #(.PER_W(PER_W), .MAX_BYTES(MAX_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .poll_req(poll_req),
    .blocked(blk_q), .waiting(waiting_rsp), .rsp_valid(rsp_valid),
    .rsp_len(rsp_len), .pkt_wr_en(pkt_wr_en), .pkt_wr_data(pkt_wr_data),
    .pkt_wr_last(pkt_wr_last), .period_q(period_q)
);

// File: tb/autopoll_sched_test.sv
`timescale 1ns/1ps
module autopoll_sched_test;
    localparam int CYC = 5;
    localparam int MB  = 8;

    typedef struct packed {
        logic [7:0]  per;
        logic [15:0] mask;
        logic [3:0]  len;
        logic [63:0] data;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{per: 8'd2, mask: 16'h1234, len: 4'd2,  data: 64'h55AA},
        '{per: 8'd3, mask: 16'h8001, len: 4'd12, data: 64'h0807060504030201},
        '{per: 8'd4, mask: 16'h00FF, len: 4'd0,  data: 64'h0},
        '{per: 8'd1, mask: 16'hFFFF, len: 4'd1,  data: 64'h7E}
    };

    logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0;
    logic        period_we = 1'b0, mask_we = 1'b0;
    logic [7:0]  period_ms = '0, mask_byte = '0;
    logic        host_block = 1'b0, host_unblock = 1'b0;
    logic        poll_req;
    logic [15:0] poll_mask;
    logic        rsp_valid = 1'b0;
    logic [3:0]  rsp_len = '0;
    logic [63:0] rsp_data = '0;
    logic        pkt_wr_en, pkt_wr_last;
    logic [7:0]  pkt_wr_data;

    int n_cmp = 0, n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    autopoll_sched #(.CYC_PER_MS(CYC), .DEF_PER(3)) uut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .period_we(period_we), .period_ms(period_ms),
        .mask_we(mask_we), .mask_byte(mask_byte),
        .host_block(host_block), .host_unblock(host_unblock),
        .poll_req(poll_req), .poll_mask(poll_mask),
        .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_data(rsp_data),
        .pkt_wr_en(pkt_wr_en), .pkt_wr_data(pkt_wr_data), .pkt_wr_last(pkt_wr_last)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_period(input logic [7:0] v);
        period_we = 1'b1; period_ms = v;
        @(negedge clk);
        period_we = 1'b0;
    endtask

    task automatic set_mask(input logic [15:0] m);
        mask_we = 1'b1; mask_byte = m[15:8];
        @(negedge clk);
        mask_byte = m[7:0];
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    // n negedges, each required to show no poll strobe.
    task automatic quiet(input int n, input string req);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (poll_req) hits++;
        end
        chk(hits == 0, req, hits, 0);
    endtask

    // Wait for a strobe; returns cycles elapsed since the start cycle.
    task automatic wait_poll(input int t0, output int lat);
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!poll_req && guard < 400);
        lat = cyc - t0;
    endtask

    // Called on the negedge showing the strobe; answers and checks the packet.
    task automatic answer(input logic [3:0] len, input logic [63:0] data);
        int n;
        logic [7:0] e;
        rsp_valid = 1'b1; rsp_len = len; rsp_data = data;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(!poll_req, "R5 strobe one cycle", poll_req, 0);
        n = (len > MB) ? MB : int'(len);
        if (n == 0) begin
            chk(!pkt_wr_en, "R7 no write for empty answer", pkt_wr_en, 0);
            @(negedge clk);
            chk(!pkt_wr_en, "R7 no write for empty answer", pkt_wr_en, 0);
        end else begin
            for (int b = 0; b < n + 2; b++) begin
                e = (b == 0) ? 8'h00 : (b == 1) ? 8'h40 : data[8*(b-2) +: 8];
                chk(pkt_wr_en && pkt_wr_data == e && pkt_wr_last == (b == n + 1),
                    (len > MB) ? "R9 clamped packet byte" : "R6 packet byte",
                    {pkt_wr_en, pkt_wr_last, pkt_wr_data}, {1'b1, b == n + 1, e});
                @(negedge clk);
            end
            chk(!pkt_wr_en, "R6 packet ends after last", pkt_wr_en, 0);
        end
    endtask

    initial begin
        int t0, lat;
        repeat (3) @(negedge clk);
        chk(!poll_req && !pkt_wr_en && poll_mask == 16'h0, "R1 reset state",
            {poll_req, pkt_wr_en, poll_mask}, 0);
        rst_n = 1'b1;
        quiet(100, "R1 no poll while disabled");

        // Vector table: period, mask, answer length and data.
        for (int v = 0; v < 4; v++) begin
            set_period(VEC[v].per);
            set_mask(VEC[v].mask);
            chk(poll_mask == VEC[v].mask, "R4 mask high byte first", poll_mask, VEC[v].mask);
            en = 1'b1; t0 = cyc;
            wait_poll(t0, lat);
            chk(lat == VEC[v].per * CYC, "R2 first poll latency", lat, VEC[v].per * CYC);
            chk(poll_req && poll_mask == VEC[v].mask, "R5 strobe carries mask",
                poll_mask, VEC[v].mask);
            t0 = cyc;
            answer(VEC[v].len, VEC[v].data);
            wait_poll(t0, lat);
            chk(lat == VEC[v].per * CYC, "R2 poll interval", lat, VEC[v].per * CYC);
            answer(4'd0, 64'h0);
            en = 1'b0;
            @(negedge clk);
        end

        // Zero period write ignored.
        set_period(8'd2);
        set_period(8'd0);
        en = 1'b1; t0 = cyc;
        wait_poll(t0, lat);
        chk(lat == 2 * CYC, "R3 zero period rejected", lat, 2 * CYC);
        answer(4'd0, 64'h0);
        en = 1'b0;
        @(negedge clk);

        // Block across three expiries, then a release landing on an expiry.
        set_period(8'd2);
        en = 1'b1; host_block = 1'b1;            // negedge k
        @(negedge clk); host_block = 1'b0;       // k+1
        quiet(31, "R8 no poll while blocked");   // k+2..k+32
        host_unblock = 1'b1;
        @(negedge clk); host_unblock = 1'b0;     // k+33
        chk(!poll_req, "R8 no poll before release edge", poll_req, 0);
        @(negedge clk);                          // k+34
        chk(poll_req, "R8 held poll issued after release", poll_req, 1);
        rsp_valid = 1'b1; rsp_len = 4'd0;
        @(negedge clk); rsp_valid = 1'b0; host_block = 1'b1;   // k+35
        chk(!poll_req, "R8 collapsed expiries give one poll", poll_req, 0);
        @(negedge clk); host_block = 1'b0;       // k+36
        quiet(12, "R8 no poll while blocked");   // k+37..k+48
        host_unblock = 1'b1;
        @(negedge clk); host_unblock = 1'b0;     // k+49
        chk(!poll_req, "R8 no poll before release edge", poll_req, 0);
        @(negedge clk);                          // k+50
        chk(poll_req, "R8 release on expiry issues poll", poll_req, 1);
        rsp_valid = 1'b1; rsp_len = 4'd0;
        @(negedge clk); rsp_valid = 1'b0;        // k+51
        chk(!poll_req && !pkt_wr_en, "R7 merged poll silent", {poll_req, pkt_wr_en}, 0);
        quiet(8, "R8 no duplicate after merge"); // k+52..k+59
        @(negedge clk);                          // k+60
        chk(poll_req, "R2 grid kept after merge", poll_req, 1);
        rsp_valid = 1'b1; rsp_len = 4'd0;
        @(negedge clk); rsp_valid = 1'b0; en = 1'b0;
        quiet(30, "R1 no poll after disable");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule